// File: doc/BRIEF.md
# Operand address decoder

This block sits behind an instruction byte aligner and turns the operand-specifier bytes of a variable-length instruction into an operand. The bytes arrive on a valid/ready byte stream. The first byte is always a mode byte. Certain combinations of its fields call for an extra scale/index/base byte, then a one-byte or four-byte displacement. As a result, one operand specifier takes between one and six bytes.

When the last byte of a specifier has been taken, the block presents its result for exactly one cycle. The result carries:
- the register named by the mode byte's second-operand field;
- a flag that tells a register operand from a memory operand;
- for memory operands, a full effective address built from base, scaled index and displacement.

Base and index values are read from the surrounding register file through two combinational read ports. The block drives the selectors and uses the returned data in the same cycle.

Top module: `addr_spec_decoder`

## Requirements
- R1: `in_ready` is high while the block waits for a specifier byte and low in the result cycle. A byte is taken only on a cycle with `in_valid` and `in_ready` both high. `out_valid` is high for exactly one cycle, the cycle after the last byte of a specifier is taken, and never otherwise.
- R2: The mode byte holds the mode in bits [7:6], the second-operand register in bits [5:3] and the first-operand field in bits [2:0]. Mode 11 is a one-byte register operand: `out_is_mem` is 0, `out_rm_reg` carries bits [2:0] and `out_addr` is 0.
- R3: `out_reg_sel` always carries bits [5:3] of the mode byte, and `out_rm_reg` always carries bits [2:0].
- R4: Mode 00 with a first-operand field other than 100 or 101 is a one-byte memory operand. Its address is the value of the register named by bits [2:0].
- R5: Mode 01 takes one displacement byte. It is sign-extended to 32 bits and added to the address.
- R6: Mode 10 takes four displacement bytes, least significant first, which are added to the address.
- R7: Mode 00 with field 101 takes four bytes, least significant first, as a direct address with no register term.
- R8: When the mode is not 11 and field [2:0] is 100, the next byte is a scale/index/base byte. It holds the scale exponent in bits [7:6], the index register in [5:3] and the base register in [2:0], and it comes before any displacement. The address is index × 2^scale + base + displacement.
- R9: An index field of 100 drops the index term.
- R10: A base field of 101 with mode 00 drops the base term and takes a four-byte displacement. With mode 01 or 10, base 101 names register 5 like any other base.
- R11: Asserting `rst_n` abandons a partly received specifier. After reset the block waits for a mode byte, with `in_ready` high and `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A specifier byte is offered |
| in_data | input | 8 | Specifier byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| rf_base_sel | output | 3 | Register file read port A selector (base) |
| rf_base_data | input | 32 | Register file read port A data |
| rf_index_sel | output | 3 | Register file read port B selector (index) |
| rf_index_data | input | 32 | Register file read port B data |
| out_valid | output | 1 | One-cycle result strobe |
| out_is_mem | output | 1 | 1 for a memory operand, 0 for a register operand |
| out_reg_sel | output | 3 | Second-operand register number |
| out_rm_reg | output | 3 | First-operand field (register number in register mode) |
| out_addr | output | 32 | Effective address, 0 for register operands |

## Verification
The bench builds the block with its default address width of 32 bits. That width gives a four-lane displacement and a two-bit byte counter, so every form is reachable: the one-byte register form, the full six-byte form (mode byte, scale/index/base byte and a 32-bit displacement) and the bare direct address. The bench's register file holds distinct values in every register, including ones with the top bit set. With these values, a wrong base or index selection changes the address, and so do a missed sign extension, a swapped byte order and the wrong scale. Gaps between bytes and an abandoned specifier check that a byte is consumed only under the handshake.

// File: rtl/asd_pkg.sv
`timescale 1ns/1ps
package asd_pkg;

  typedef enum logic [1:0] {
    ST_MODE = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2,
    ST_DONE = 2'd3
  } asd_state_e;

  typedef struct packed {
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;
  } modrm_t;

  typedef struct packed {
    logic [1:0] scale;
    logic [2:0] index;
    logic [2:0] base;
  } sib_t;

  localparam logic [1:0] MOD_IND = 2'b00;
  localparam logic [1:0] MOD_D8  = 2'b01;
  localparam logic [1:0] MOD_D32 = 2'b10;
  localparam logic [1:0] MOD_REG = 2'b11;

  localparam logic [2:0] RM_SIB    = 3'b100;
  localparam logic [2:0] RM_NOBASE = 3'b101;
  localparam logic [2:0] IDX_NONE  = 3'b100;

endpackage

// File: rtl/asd_rst_sync.sv
`timescale 1ns/1ps
module asd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/asd_seq.sv
`timescale 1ns/1ps
module asd_seq
  import asd_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int DISP_BYTES = ADDR_W / 8,
  localparam int BCW = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  output logic           in_ready,
  output logic           done_o,
  output modrm_t         mode_o,
  output sib_t           sib_o,
  output logic           has_sib_o,
  output logic           disp_clr_o,
  output logic           disp_we_o,
  output logic [BCW-1:0] disp_idx_o
);

  localparam logic [BCW-1:0] IDX_LAST = BCW'(DISP_BYTES - 1);

  asd_state_e     state_q, state_d;
  modrm_t         mode_q;
  sib_t           sib_q;
  logic           has_sib_q, has_sib_d;
  logic [BCW-1:0] idx_q, idx_d;
  logic [BCW-1:0] last_q, last_d;
  logic           accept;
  logic           mode_en, sib_en;
  modrm_t         mb;
  sib_t           sb;

  assign in_ready = (state_q != ST_DONE);
  assign accept   = in_valid && in_ready;
  assign mode_en  = accept && (state_q == ST_MODE);
  assign sib_en   = accept && (state_q == ST_SIB);
  assign mb       = modrm_t'(in_data);
  assign sb       = sib_t'(in_data);

  // next-state process
  always_comb begin
    state_d   = state_q;
    has_sib_d = has_sib_q;
    idx_d     = idx_q;
    last_d    = last_q;
    unique case (state_q)
      ST_MODE: begin
        if (accept) begin
          has_sib_d = 1'b0;
          idx_d     = '0;
          if (mb.md == MOD_REG) begin
            state_d = ST_DONE;
          end else if (mb.rm == RM_SIB) begin
            state_d   = ST_SIB;
            has_sib_d = 1'b1;
          end else if (mb.md == MOD_D8) begin
            state_d = ST_DISP;
            last_d  = '0;
          end else if (mb.md == MOD_D32 || mb.rm == RM_NOBASE) begin
            state_d = ST_DISP;
            last_d  = IDX_LAST;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_SIB: begin
        if (accept) begin
          idx_d = '0;
          if (mode_q.md == MOD_D8) begin
            state_d = ST_DISP;
            last_d  = '0;
          end else if (mode_q.md == MOD_D32 || sb.base == RM_NOBASE) begin
            state_d = ST_DISP;
            last_d  = IDX_LAST;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_DISP: begin
        if (accept) begin
          if (idx_q == last_q) begin
            state_d = ST_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_MODE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_MODE;
      mode_q    <= '0;
      sib_q     <= '0;
      has_sib_q <= 1'b0;
      idx_q     <= '0;
      last_q    <= '0;
    end else begin
      state_q   <= state_d;
      has_sib_q <= has_sib_d;
      idx_q     <= idx_d;
      last_q    <= last_d;
      if (mode_en) begin
        mode_q <= mb;
      end
      if (sib_en) begin
        sib_q <= sb;
      end
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign mode_o     = mode_q;
  assign sib_o      = sib_q;
  assign has_sib_o  = has_sib_q;
  assign disp_clr_o = mode_en;
  assign disp_we_o  = accept && (state_q == ST_DISP);
  assign disp_idx_o = idx_q;

  // R1: the result strobe lasts one cycle
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1: no byte is requested while the result is shown
  a_r1_no_ready_in_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !in_ready);

  // R8: the scale/index/base byte is only expected directly after a mode byte
  a_r8_sib_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIB) |-> ($past(state_q) == ST_MODE || $past(state_q) == ST_SIB));

  // R10: the displacement lane index stays within the announced length
  a_r10_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DISP) |-> (idx_q <= last_q));

endmodule

// File: rtl/asd_disp.sv
`timescale 1ns/1ps
module asd_disp #(
  parameter int ADDR_W = 32,
  localparam int DISP_BYTES = ADDR_W / 8,
  localparam int BCW = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [BCW-1:0]    idx_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] disp_o
);

  for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;

    assign lane_en = we_i && (idx_i == BCW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (clr_i) begin
        lane_q <= '0;
      end else if (lane_en) begin
        lane_q <= byte_i;
      end
    end

    assign disp_o[g*8 +: 8] = lane_q;
  end

  // R11: starting a new specifier leaves no stale displacement behind
  a_r11_disp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (disp_o == '0));

endmodule

// File: rtl/asd_agen.sv
`timescale 1ns/1ps
module asd_agen
  import asd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  modrm_t            mode_i,
  input  sib_t              sib_i,
  input  logic              has_sib_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [2:0]        base_sel_o,
  input  logic [ADDR_W-1:0] base_data_i,
  output logic [2:0]        index_sel_o,
  input  logic [ADDR_W-1:0] index_data_i,
  output logic              is_mem_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              no_base;
  logic              use_index;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;

  assign base_sel_o  = has_sib_i ? sib_i.base : mode_i.rm;
  assign index_sel_o = sib_i.index;
  assign is_mem_o    = (mode_i.md != MOD_REG);

  assign no_base   = (mode_i.md == MOD_IND) && (base_sel_o == RM_NOBASE);
  assign use_index = has_sib_i && (sib_i.index != IDX_NONE);

  assign base_term  = no_base ? '0 : base_data_i;
  assign index_term = use_index ? (index_data_i << sib_i.scale) : '0;
  assign disp_term  = (mode_i.md == MOD_D8) ? {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]} : disp_i;

  assign addr_o = is_mem_o ? (base_term + index_term + disp_term) : '0;

endmodule

// File: rtl/addr_spec_decoder.sv
`timescale 1ns/1ps
module addr_spec_decoder
  import asd_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int DISP_BYTES = ADDR_W / 8,
  localparam int BCW = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic [2:0]        rf_base_sel,
  input  logic [ADDR_W-1:0] rf_base_data,
  output logic [2:0]        rf_index_sel,
  input  logic [ADDR_W-1:0] rf_index_data,
  output logic              out_valid,
  output logic              out_is_mem,
  output logic [2:0]        out_reg_sel,
  output logic [2:0]        out_rm_reg,
  output logic [ADDR_W-1:0] out_addr
);

  logic              rst_n_sync;
  modrm_t            mode;
  sib_t              sib;
  logic              has_sib;
  logic              disp_clr;
  logic              disp_we;
  logic [BCW-1:0]    disp_idx;
  logic [ADDR_W-1:0] disp;

  asd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  asd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .done_o     (out_valid),
    .mode_o     (mode),
    .sib_o      (sib),
    .has_sib_o  (has_sib),
    .disp_clr_o (disp_clr),
    .disp_we_o  (disp_we),
    .disp_idx_o (disp_idx)
  );

  asd_disp #(.ADDR_W(ADDR_W)) u_disp (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .clr_i  (disp_clr),
    .we_i   (disp_we),
    .idx_i  (disp_idx),
    .byte_i (in_data),
    .disp_o (disp)
  );

  asd_agen #(.ADDR_W(ADDR_W)) u_agen (
    .mode_i       (mode),
    .sib_i        (sib),
    .has_sib_i    (has_sib),
    .disp_i       (disp),
    .base_sel_o   (rf_base_sel),
    .base_data_i  (rf_base_data),
    .index_sel_o  (rf_index_sel),
    .index_data_i (rf_index_data),
    .is_mem_o     (out_is_mem),
    .addr_o       (out_addr)
  );

  assign out_reg_sel = mode.rg;
  assign out_rm_reg  = mode.rm;

  // R2: a register operand never carries an address
  a_r2_reg_addr_zero: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (out_valid && !out_is_mem) |-> (out_addr == '0));

endmodule

// File: tb/addr_spec_decoder_tb.sv
`timescale 1ns/1ps
module addr_spec_decoder_tb;

  typedef struct packed {
    logic [47:0] bytes;
    logic [2:0]  nb;
    logic        is_mem;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [31:0] addr;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{48'h0000000000D3, 3'd1, 1'b0, 3'd2, 3'd3, 32'h00000000},
    '{48'h000000000008, 3'd1, 1'b1, 3'd1, 3'd0, 32'h00001000},
    '{48'h00000000F046, 3'd2, 1'b1, 3'd0, 3'd6, 32'hFFFFFFF7},
    '{48'h0012345678B9, 3'd5, 1'b1, 3'd7, 3'd1, 32'h32345688},
    '{48'h00DEADBEEF1D, 3'd5, 1'b1, 3'd3, 3'd5, 32'hDEADBEEF},
    '{48'h000000008304, 3'd2, 1'b1, 3'd0, 3'd4, 32'h00004400},
    '{48'h00000008D544, 3'd3, 1'b1, 3'd0, 3'd4, 32'h00600188},
    '{48'h000000012684, 3'd6, 1'b1, 3'd0, 3'd4, 32'h00000008},
    '{48'h000100004D04, 3'd6, 1'b1, 3'd0, 3'd4, 32'h40010020},
    '{48'h000000002404, 3'd2, 1'b1, 3'd0, 3'd4, 32'h00050000},
    '{48'h000000007F45, 3'd2, 1'b1, 3'd0, 3'd5, 32'h0060007F}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R10";
      7: return "R9";
      8: return "R10";
      9: return "R9";
      default: return "R5";
    endcase
  endfunction

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic [2:0]  rf_base_sel;
  logic [31:0] rf_base_data;
  logic [2:0]  rf_index_sel;
  logic [31:0] rf_index_data;
  logic        out_valid;
  logic        out_is_mem;
  logic [2:0]  out_reg_sel;
  logic [2:0]  out_rm_reg;
  logic [31:0] out_addr;

  logic [31:0] rf [8];
  int checks;
  int fails;
  int vcount;
  int vexp;

  assign rf_base_data  = rf[rf_base_sel];
  assign rf_index_data = rf[rf_index_sel];

  addr_spec_decoder u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .rf_base_sel   (rf_base_sel),
    .rf_base_data  (rf_base_data),
    .rf_index_sel  (rf_index_sel),
    .rf_index_data (rf_index_data),
    .out_valid     (out_valid),
    .out_is_mem    (out_is_mem),
    .out_reg_sel   (out_reg_sel),
    .out_rm_reg    (out_rm_reg),
    .out_addr      (out_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (out_valid) vcount <= vcount + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input int gap);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_data  = 8'h5A;
  endtask

  task automatic expect_result(input string tag, input logic is_mem, input logic [2:0] rg,
                               input logic [2:0] rm, input logic [31:0] addr);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1", "out_valid after last byte", 32'(out_valid), 32'd1);
    chk(in_ready == 1'b0, "R1", "in_ready in result cycle", 32'(in_ready), 32'd0);
    chk(out_is_mem == is_mem, tag, "out_is_mem", 32'(out_is_mem), 32'(is_mem));
    chk(out_reg_sel == rg, "R3", "out_reg_sel", 32'(out_reg_sel), 32'(rg));
    chk(out_rm_reg == rm, "R3", "out_rm_reg", 32'(out_rm_reg), 32'(rm));
    chk(out_addr == addr, tag, "out_addr", out_addr, addr);
    @(posedge clk);
    #1;
    vexp++;
    chk(vcount == vexp, "R1", "result strobe count", 32'(vcount), 32'(vexp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    vcount   = 0;
    vexp     = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    rf[0] = 32'h00001000;
    rf[1] = 32'h20000010;
    rf[2] = 32'h00000030;
    rf[3] = 32'h00000400;
    rf[4] = 32'h00050000;
    rf[5] = 32'h00600000;
    rf[6] = 32'h00000007;
    rf[7] = 32'h80000000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 32'(out_valid), 32'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      for (int k = 0; k < int'(VEC[i].nb); k++) begin
        push(VEC[i].bytes[k*8 +: 8], (i + k) % 3);
      end
      expect_result(vtag(i), VEC[i].is_mem, VEC[i].rg, VEC[i].rm, VEC[i].addr);
    end

    // R1: bytes offered without in_valid are not taken
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'hC0;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "no strobe without in_valid", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R1", "still waiting for mode byte", 32'(in_ready), 32'd1);
    push(8'h08, 0);
    expect_result("R4", 1'b1, 3'd1, 3'd0, 32'h00001000);

    // R11: abandon a specifier halfway through its displacement
    push(8'h84, 0);
    push(8'h26, 1);
    push(8'hAA, 0);
    push(8'hBB, 0);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R11", "in_ready after mid-specifier reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R11", "out_valid after mid-specifier reset", 32'(out_valid), 32'd0);
    chk(vcount == vexp, "R11", "no strobe from abandoned specifier", 32'(vcount), 32'(vexp));
    push(8'hF3, 0);
    expect_result("R11", 1'b0, 3'd6, 3'd3, 32'h00000000);
    push(8'h45, 2);
    push(8'h80, 0);
    expect_result("R5", 1'b1, 3'd0, 3'd5, 32'h005FFF80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule